// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block divides a fast oscillator clock by a programmable ratio and emits a single-clock pulse once per divided period, for use as the feedback input of a phase detector. It is built from three cooperating counters. A dual-modulus prescaler divides by P+1 or by P. A 7-bit swallow count A sets how many prescaler cycles use P+1. An 11-bit main count N sets how many prescaler cycles make one output period. The prescaler runs at P+1 until the swallow count is used up and at P for the rest of the period, so one output period lasts P·N + A input clocks.

A single select input picks the modulus pair. A build parameter chooses which of two bands the instance serves. The low band offers 32 or 64, and the high band offers 64 or 128. The A, N and select inputs may change at any time. They are captured only on the edge that ends a period, so a period in progress is never disturbed. If the captured swallow count exceeds the effective main count, an error output flags that period.

Top module: `swallow_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` and `ratio_err` are both 0.
- R2: When A ≤ N (with N ≥ 3), consecutive rising edges of `div_pulse` are exactly P·N + A input clocks apart, and each pulse is high for exactly one clock.
- R3: With the low-band build (`HIGH_BAND`=0), a captured `band_sel` of 1 gives P = 32 and a value of 0 gives P = 64.
- R4: With the high-band build (`HIGH_BAND`=1), a captured `band_sel` of 1 gives P = 64 and a value of 0 gives P = 128.
- R5: `swallow_a`, `main_n` and `band_sel` are sampled only on the clock edge that raises `div_pulse`. Changes made during a period do not alter that period's length, and `ratio_err` changes only on that edge.
- R6: If the captured A exceeds the effective N, `ratio_err` is 1 for that whole period and the period lasts (P+1)·N clocks. Otherwise `ratio_err` is 0.
- R7: A `main_n` value below 3 is treated as 3.
- R8: After reset is released, the first edge loads the inputs. The first pulse is raised on the (P·N + A + 1)-th rising edge after release.
- R9: The end cases A = 0 (period P·N) and A = N (period (P+1)·N) follow the formula in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| swallow_a | input | 7 | Swallow count A, 0..127 |
| main_n | input | 11 | Main count N, 3..2047 (smaller values are raised to 3) |
| band_sel | input | 1 | Modulus pair select: 1 picks the smaller P |
| div_pulse | output | 1 | One-clock pulse per divided period |
| ratio_err | output | 1 | Set for a period whose captured A exceeds N |

## Verification
Directed vectors target the edge values. A = 0 separates a plain P·N count from a swallowing one. A = N and A = 127 with N = 127 check that every prescaler cycle can run at P+1. A > N checks that the error path stretches the period to (P+1)·N. N = 1 and N = 2 check the clamp to 3. Both `band_sel` values are used on both band builds, which distinguishes the four prescaler moduli. Random A, N and select values then change on every period two clocks after the pulse. Each measured interval is compared with the settings captured at the previous pulse, so an early take-over of the new values shows up as a wrong period length.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter bit HIGH_BAND = 1'b0,
  parameter int A_W = 7,
  parameter int N_W = 11,
  parameter int N_MIN = 3
) (
  input  logic           clk_vco,
  input  logic           rst_n,
  input  logic [A_W-1:0] swallow_a,
  input  logic [N_W-1:0] main_n,
  input  logic           band_sel,
  output logic           div_pulse,
  output logic           ratio_err
);
  localparam int P_SMALL = HIGH_BAND ? 64 : 32;
  localparam int P_LARGE = 2 * P_SMALL;
  localparam int PC_W = $clog2(P_LARGE + 2);

  logic           armed;
  logic [PC_W-1:0] pre_cnt;
  logic [PC_W-1:0] p_q;
  logic [A_W-1:0]  a_rem;
  logic [N_W-1:0]  n_rem;
  logic            pulse_q;
  logic            err_q;

  wire [N_W-1:0]  n_eff    = (main_n < N_W'(N_MIN)) ? N_W'(N_MIN) : main_n;
  wire [PC_W-1:0] p_in     = band_sel ? PC_W'(P_SMALL) : PC_W'(P_LARGE);
  wire            a_too_big = N_W'(swallow_a) > n_eff;
  wire [PC_W-1:0] top_pre  = (a_rem != '0) ? p_q : p_q - 1'b1;
  wire            pre_wrap = armed && (pre_cnt == top_pre);
  wire            last     = pre_wrap && (n_rem == N_W'(1));

  always_ff @(posedge clk_vco) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      pre_cnt <= '0;
      p_q     <= '0;
      a_rem   <= '0;
      n_rem   <= '0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (!armed || last) begin
      armed   <= 1'b1;
      pre_cnt <= '0;
      p_q     <= p_in;
      a_rem   <= swallow_a;
      n_rem   <= n_eff;
      err_q   <= a_too_big;
      pulse_q <= last;
    end else begin
      pulse_q <= 1'b0;
      if (pre_wrap) begin
        pre_cnt <= '0;
        n_rem   <= n_rem - 1'b1;
        if (a_rem != '0) a_rem <= a_rem - 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  assign div_pulse = pulse_q;
  assign ratio_err = err_q;
endmodule

module swallow_divider_chk #(
  parameter int A_W = 7,
  parameter int N_W = 11,
  parameter int PC_W = 8
) (
  input logic            clk_vco,
  input logic            rst_n,
  input logic [A_W-1:0]  swallow_a,
  input logic [N_W-1:0]  main_n,
  input logic            div_pulse,
  input logic            ratio_err,
  input logic            armed,
  input logic [PC_W-1:0] pre_cnt,
  input logic [PC_W-1:0] p_q,
  input logic [N_W-1:0]  n_rem
);
  assert_pulse_one_wide_R2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_err_only_at_boundary_R5: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (!div_pulse && $past(armed)) |-> $stable(ratio_err));

  assert_err_matches_capture_R6: assert property (@(posedge clk_vco) disable iff (!rst_n)
    div_pulse |-> (ratio_err == (N_W'($past(swallow_a)) >
      (($past(main_n) < N_W'(3)) ? N_W'(3) : $past(main_n)))));

  assert_no_pulse_before_load_R8: assert property (@(posedge clk_vco) disable iff (!rst_n)
    !armed |-> !div_pulse);

  assert_prescaler_bound_R3: assert property (@(posedge clk_vco) disable iff (!rst_n)
    armed |-> (pre_cnt <= p_q));

  assert_main_count_live_R7: assert property (@(posedge clk_vco) disable iff (!rst_n)
    armed |-> (n_rem != '0));
endmodule

bind swallow_divider swallow_divider_chk #(.A_W(A_W), .N_W(N_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst_n;
  logic [6:0]  a_lo, a_hi;
  logic [10:0] n_lo, n_hi;
  logic        sel_lo, sel_hi;
  logic        pulse_lo, err_lo, pulse_hi, err_hi;

  int checks = 0;
  int fails = 0;

  swallow_divider #(.HIGH_BAND(1'b0)) u_dut (
    .clk_vco(clk), .rst_n(rst_n), .swallow_a(a_lo), .main_n(n_lo),
    .band_sel(sel_lo), .div_pulse(pulse_lo), .ratio_err(err_lo));

  swallow_divider #(.HIGH_BAND(1'b1)) u_dut_hi (
    .clk_vco(clk), .rst_n(rst_n), .swallow_a(a_hi), .main_n(n_hi),
    .band_sel(sel_hi), .div_pulse(pulse_hi), .ratio_err(err_hi));

  function automatic int eff_n(int n);
    return (n < 3) ? 3 : n;
  endfunction

  function automatic int exp_len(int a, int n, bit sel, bit hi);
    int nn = eff_n(n);
    int p = hi ? (sel ? 64 : 128) : (sel ? 32 : 64);
    return (a > nn) ? (p + 1) * nn : p * nn + a;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  // Counts clocks to the next pulse; new settings are applied two clocks in.
  task automatic run_lo(int a, int n, bit sel, int expv, string req, bit chk_width);
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 1 && chk_width) check("R2 pulse width", int'(pulse_lo), 0);
      if (cnt == 2) begin a_lo = 7'(a); n_lo = 11'(n); sel_lo = sel; end
      if (pulse_lo || cnt > 300000) break;
    end
    if (expv >= 0) check(req, cnt, expv);
    check("R6 error flag", int'(err_lo), int'(a > eff_n(n)));
  endtask

  task automatic run_hi(int a, int n, bit sel, int expv, string req);
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt++;
      if (cnt == 2) begin a_hi = 7'(a); n_hi = 11'(n); sel_hi = sel; end
      if (pulse_hi || cnt > 300000) break;
    end
    if (expv >= 0) check(req, cnt, expv);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int pa, pn, pexp;
    bit ps;
    string preq;
    void'($urandom(32'h1F2E3D));
    rst_n = 1'b0;
    a_lo = 7'd4; n_lo = 11'd6; sel_lo = 1'b1;
    a_hi = 7'd2; n_hi = 11'd3; sel_hi = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R1 pulse in reset", int'(pulse_lo), 0);
      check("R1 err in reset", int'(err_lo), 0);
    end
    rst_n = 1'b1;
    // R8: first period counted from release
    run_lo(0, 3, 1, exp_len(4, 6, 1, 0) + 1, "R8 first pulse", 1'b0);
    pa = 0; pn = 3; ps = 1; preq = "R9 A=0";

    begin
      int da[8] = '{3, 5, 127, 10, 0, 2, 9, 1};
      int dn[8] = '{3, 10, 127, 5, 1, 2, 9, 40};
      bit ds[8] = '{1, 0, 1, 1, 1, 0, 0, 0};
      string dr[8] = '{"R9 A=N", "R3 P=64", "R9 A=N=127", "R6 A>N",
                       "R7 N=1 clamp", "R7 N=2 clamp", "R9 A=N P=64", "R2 basic"};
      for (int i = 0; i < 8; i++) begin
        pexp = exp_len(pa, pn, ps, 0);
        run_lo(da[i], dn[i], ds[i], pexp, preq, 1'b1);
        pa = da[i]; pn = dn[i]; ps = ds[i]; preq = dr[i];
      end
    end

    for (int i = 0; i < 40; i++) begin
      int na, nn;
      bit nsel;
      nn = 3 + int'($urandom_range(0, 57));
      na = ($urandom_range(0, 7) == 0) ? nn + 1 + int'($urandom_range(0, 5))
                                      : int'($urandom_range(0, nn));
      nsel = 1'($urandom_range(0, 1));
      pexp = exp_len(pa, pn, ps, 0);
      run_lo(na, nn, nsel, pexp, preq, 1'b1);
      pa = na; pn = nn; ps = nsel;
      preq = (na > nn) ? "R6 random A>N" : "R5 random mid-period change";
    end
    pexp = exp_len(pa, pn, ps, 0);
    run_lo(pa, pn, ps, pexp, preq, 1'b1);

    run_hi(2, 3, 1, -1, "sync");
    run_hi(2, 3, 0, exp_len(2, 3, 1, 1), "R4 P=64");
    run_hi(2, 3, 0, exp_len(2, 3, 0, 1), "R4 P=128");
    check("R4 hi err", int'(err_hi), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule